// File: doc/BRIEF.md
# Scatter-Gather DMA Engine

This block is the bus-master data mover for one disk-interface channel. Software builds a chain of descriptors in memory, writes the chain's base and the address of a 128-byte completion area into registers, then sets the start bit together with a direction. The engine reads the descriptors one after another and moves 32-bit words between the device stream ports and memory. The direction bit selects which way the words go.

When the last descriptor has been processed, or when software asks for a halt, the engine fills the completion area with all-ones words and then pulses its interrupt. Software can poll that area to see that the transfer is over, even when its register reads and the engine's memory writes may arrive out of order. A memory error response stops the engine at once and latches an error flag. Two byte counters report progress on the device side and on the memory side.

Top module: `sg_dma_engine`

## Requirements
- R1: Registers are 32 bits wide and selected by a word offset on `reg_addr`: 0 timing, 1 list base low, 2 list base high, 3 current buffer address, 4 current address high (reads 0), 5 device byte count, 6 memory byte count, 7 control/status, 8 completion-area base. Offsets 0, 1, 2 and 8 read back what was written. Every register reads 0 after reset.
- R2: A descriptor is four 32-bit words at consecutive word addresses, stored big-endian. The engine reads only word 1 (the buffer address) and word 3 (length in bits 15:0, end-of-list flag in bit 31). The next descriptor starts 16 bytes later.
- R3: With the control direction bit (bit 2) clear, words are read from memory and presented on `dev_out_*`, in descriptor order and in ascending address order.
- R4: With the direction bit set, words taken from `dev_in_*` are written to memory at ascending addresses, in descriptor order.
- R5: The device and memory byte counters are cleared when a start is accepted. Each counter grows by 4 for every word moved on its side. Offset 3 holds the address of the next buffer word.
- R6: A descriptor length of zero moves 65536 bytes.
- R7: After the end-of-list descriptor completes, active (control bit 3) clears. The engine then writes 32 all-ones words to the completion area and raises `irq` for exactly one cycle, while active is low.
- R8: Writing control bit 1 requests a stop, and the bit reads back as 1 until the engine is idle again. A running engine halts at the next word boundary, writes the completion area and pulses `irq`. A stop written while idle reads 1 in the cycle after the write and 0 one cycle later. Direction writes are ignored while the engine is busy.
- R9: A memory response with `mem_rsp_err` set sets the error bit (control bit 4), clears active and halts with no completion write and no interrupt. While the error bit is set, start writes are ignored. Only a stop write clears the error bit.
- R10: A memory request holds its address, write flag and data stable until `mem_req_ready` accepts it. Only one request is outstanding at a time, and each request gets one response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register word offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address of the request |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Response for the outstanding request |
| mem_rsp_err | input | 1 | Response carries an error |
| mem_rsp_rdata | input | 32 | Read data |
| dev_in_valid | input | 1 | Device word available |
| dev_in_ready | output | 1 | Engine takes the device word |
| dev_in_data | input | 32 | Device word |
| dev_out_valid | output | 1 | Word for the device available |
| dev_out_ready | input | 1 | Device takes the word |
| dev_out_data | output | 32 | Word for the device |
| irq | output | 1 | One-cycle done pulse |

## Verification
A register write takes effect at the next clock edge, and register reads are combinational, so the bench samples a register half a cycle after it drives the offset. A stop written while the engine is idle is checked in the cycle after the write (reads 1) and again two cycles later (reads 0). A running engine needs one more cycle to leave its current word before active drops, so the bench waits several cycles before it expects the stop state. The interrupt lasts a single cycle, so the bench watches for it at every falling edge and reads the control register in that same half cycle to confirm that active is already low. Memory contents, completion words and byte counters are checked only after the interrupt, and the error case is checked after a fixed wait well past the single failing response.

// File: rtl/sg_dma_pkg.sv
package sg_dma_pkg;
  localparam int DATA_W   = 32;
  localparam int REG_AW   = 4;
  localparam int LEN_W    = 16;

  localparam logic [REG_AW-1:0] OFF_TIMING  = 4'd0;
  localparam logic [REG_AW-1:0] OFF_LIST_LO = 4'd1;
  localparam logic [REG_AW-1:0] OFF_LIST_HI = 4'd2;
  localparam logic [REG_AW-1:0] OFF_CUR_LO  = 4'd3;
  localparam logic [REG_AW-1:0] OFF_CUR_HI  = 4'd4;
  localparam logic [REG_AW-1:0] OFF_DEV_CNT = 4'd5;
  localparam logic [REG_AW-1:0] OFF_MEM_CNT = 4'd6;
  localparam logic [REG_AW-1:0] OFF_CTRL    = 4'd7;
  localparam logic [REG_AW-1:0] OFF_DONE    = 4'd8;

  localparam int CB_START  = 0;
  localparam int CB_STOP   = 1;
  localparam int CB_DIR    = 2;
  localparam int CB_ACTIVE = 3;
  localparam int CB_ERR    = 4;

  typedef enum logic [3:0] {
    S_IDLE, S_DADDR_REQ, S_DADDR_WAIT, S_DLEN_REQ, S_DLEN_WAIT,
    S_BEAT, S_DEV_WAIT, S_MEM_REQ, S_MEM_WAIT, S_DEV_PUSH,
    S_MARK_REQ, S_MARK_WAIT
  } seq_state_e;

  function automatic logic [DATA_W-1:0] swap32(input logic [DATA_W-1:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/sg_dma_desc_dec.sv
module sg_dma_desc_dec
  import sg_dma_pkg::*;
#(
  parameter int LW = LEN_W,
  localparam int WCNT_W = LW - 1
) (
  input  logic [DATA_W-1:0] raw_i,
  output logic [DATA_W-1:0] addr_o,
  output logic [WCNT_W-1:0] words_o,
  output logic              eol_o
);
  logic [DATA_W-1:0] host_w;
  logic [LW:0]       len_bytes;

  // Descriptor words sit in memory most-significant byte first
  assign host_w    = swap32(raw_i);
  assign addr_o    = host_w;
  assign eol_o     = host_w[DATA_W-1];
  // R6: a zero length field stands for the full 64 KiB segment
  assign len_bytes = {~|host_w[LW-1:0], host_w[LW-1:0]};
  assign words_o   = len_bytes[LW:2];
endmodule

// File: rtl/sg_dma_regs.sv
module sg_dma_regs
  import sg_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              busy_i,
  input  logic              active_i,
  input  logic              err_set_i,
  input  logic              halt_ack_i,
  input  logic [DATA_W-1:0] cur_addr_i,
  input  logic [DATA_W-1:0] dev_cnt_i,
  input  logic [DATA_W-1:0] mem_cnt_i,
  output logic              start_o,
  output logic              start_dir_o,
  output logic              stop_o,
  output logic [DATA_W-1:0] list_base_o,
  output logic [DATA_W-1:0] done_base_o
);
  logic [DATA_W-1:0] timing_q, timing_d, list_lo_q, list_lo_d;
  logic [DATA_W-1:0] list_hi_q, list_hi_d, done_q, done_d;
  logic dir_q, dir_d, stop_q, stop_d, err_q, err_d;
  logic wr_ctrl, stop_wr;

  assign wr_ctrl     = reg_we_i && (reg_addr_i == OFF_CTRL);
  assign stop_wr     = wr_ctrl && reg_wdata_i[CB_STOP];
  assign start_o     = wr_ctrl && reg_wdata_i[CB_START] && !reg_wdata_i[CB_STOP]
                       && !busy_i && !err_q && !stop_q;
  assign start_dir_o = reg_wdata_i[CB_DIR];
  assign stop_o      = stop_q;
  assign list_base_o = list_lo_q;
  assign done_base_o = done_q;

  always_comb begin
    timing_d  = timing_q;
    list_lo_d = list_lo_q;
    list_hi_d = list_hi_q;
    done_d    = done_q;
    dir_d     = dir_q;
    stop_d    = stop_q;
    err_d     = err_q;
    if (reg_we_i) begin
      case (reg_addr_i)
        OFF_TIMING:  timing_d  = reg_wdata_i;
        OFF_LIST_LO: list_lo_d = reg_wdata_i;
        OFF_LIST_HI: list_hi_d = reg_wdata_i;
        OFF_DONE:    done_d    = reg_wdata_i;
        default: ;
      endcase
    end
    if (wr_ctrl && !busy_i) dir_d = reg_wdata_i[CB_DIR];
    if (halt_ack_i) stop_d = 1'b0;
    if (stop_wr) begin
      stop_d = 1'b1;
      err_d  = 1'b0;
    end
    if (err_set_i) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timing_q  <= '0;
      list_lo_q <= '0;
      list_hi_q <= '0;
      done_q    <= '0;
      dir_q     <= 1'b0;
      stop_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      timing_q  <= timing_d;
      list_lo_q <= list_lo_d;
      list_hi_q <= list_hi_d;
      done_q    <= done_d;
      dir_q     <= dir_d;
      stop_q    <= stop_d;
      err_q     <= err_d;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      OFF_TIMING:  reg_rdata_o = timing_q;
      OFF_LIST_LO: reg_rdata_o = list_lo_q;
      OFF_LIST_HI: reg_rdata_o = list_hi_q;
      OFF_CUR_LO:  reg_rdata_o = cur_addr_i;
      OFF_DEV_CNT: reg_rdata_o = dev_cnt_i;
      OFF_MEM_CNT: reg_rdata_o = mem_cnt_i;
      OFF_DONE:    reg_rdata_o = done_q;
      OFF_CTRL: begin
        reg_rdata_o[CB_STOP]   = stop_q;
        reg_rdata_o[CB_DIR]    = dir_q;
        reg_rdata_o[CB_ACTIVE] = active_i;
        reg_rdata_o[CB_ERR]    = err_q;
      end
      default: ;
    endcase
  end

  // R8
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_q) |-> $past(halt_ack_i));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !stop_wr |=> err_q);
endmodule

// File: rtl/sg_dma_seq.sv
module sg_dma_seq
  import sg_dma_pkg::*;
#(
  parameter int MARK_WORDS = 32,
  parameter int LW = LEN_W,
  localparam int WCNT_W = LW - 1,
  localparam int MARK_W = $clog2(MARK_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              start_dir_i,
  input  logic              stop_i,
  input  logic [DATA_W-1:0] list_base_i,
  input  logic [DATA_W-1:0] done_base_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic              mem_req_write_o,
  output logic [DATA_W-1:0] mem_req_addr_o,
  output logic [DATA_W-1:0] mem_req_wdata_o,
  input  logic              mem_rsp_valid_i,
  input  logic              mem_rsp_err_i,
  input  logic [DATA_W-1:0] mem_rsp_rdata_i,
  input  logic              dev_in_valid_i,
  output logic              dev_in_ready_o,
  input  logic [DATA_W-1:0] dev_in_data_i,
  output logic              dev_out_valid_o,
  input  logic              dev_out_ready_i,
  output logic [DATA_W-1:0] dev_out_data_o,
  output logic              busy_o,
  output logic              active_o,
  output logic              err_o,
  output logic              halt_ack_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] cur_addr_o,
  output logic [DATA_W-1:0] dev_cnt_o,
  output logic [DATA_W-1:0] mem_cnt_o
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(DATA_W / 8);

  seq_state_e st_q, st_d;
  logic              dir_q, dir_d, eol_q, eol_d, irq_q, irq_d;
  logic [DATA_W-1:0] dptr_q, dptr_d, baddr_q, baddr_d, data_q, data_d;
  logic [DATA_W-1:0] dcnt_q, dcnt_d, mcnt_q, mcnt_d;
  logic [WCNT_W-1:0] left_q, left_d;
  logic [MARK_W-1:0] midx_q, midx_d;
  logic [DATA_W-1:0] dec_addr;
  logic [WCNT_W-1:0] dec_words;
  logic              dec_eol;

  sg_dma_desc_dec #(.LW(LW)) dec_i (
    .raw_i(mem_rsp_rdata_i), .addr_o(dec_addr), .words_o(dec_words), .eol_o(dec_eol)
  );

  assign busy_o     = (st_q != S_IDLE);
  assign active_o   = busy_o && (st_q != S_MARK_REQ) && (st_q != S_MARK_WAIT);
  assign irq_o      = irq_q;
  assign cur_addr_o = baddr_q;
  assign dev_cnt_o  = dcnt_q;
  assign mem_cnt_o  = mcnt_q;
  assign dev_out_data_o = data_q;

  always_comb begin
    st_d = st_q; dir_d = dir_q; eol_d = eol_q; irq_d = 1'b0;
    dptr_d = dptr_q; baddr_d = baddr_q; data_d = data_q;
    dcnt_d = dcnt_q; mcnt_d = mcnt_q; left_d = left_q; midx_d = midx_q;
    mem_req_valid_o = 1'b0; mem_req_write_o = 1'b0;
    mem_req_addr_o = '0; mem_req_wdata_o = data_q;
    dev_in_ready_o = 1'b0; dev_out_valid_o = 1'b0;
    err_o = 1'b0; halt_ack_o = 1'b0;
    case (st_q)
      S_IDLE: begin
        halt_ack_o = stop_i;
        if (start_i) begin
          dir_d = start_dir_i; dptr_d = list_base_i;
          dcnt_d = '0; mcnt_d = '0; st_d = S_DADDR_REQ;
        end
      end
      S_DADDR_REQ: begin
        mem_req_valid_o = 1'b1;
        mem_req_addr_o  = dptr_q + STEP;
        if (mem_req_ready_i) st_d = S_DADDR_WAIT;
      end
      S_DADDR_WAIT: if (mem_rsp_valid_i) begin
        if (mem_rsp_err_i) begin err_o = 1'b1; st_d = S_IDLE; end
        else begin baddr_d = dec_addr; st_d = S_DLEN_REQ; end
      end
      S_DLEN_REQ: begin
        mem_req_valid_o = 1'b1;
        mem_req_addr_o  = dptr_q + 3 * STEP;
        if (mem_req_ready_i) st_d = S_DLEN_WAIT;
      end
      S_DLEN_WAIT: if (mem_rsp_valid_i) begin
        if (mem_rsp_err_i) begin err_o = 1'b1; st_d = S_IDLE; end
        else begin
          left_d = dec_words; eol_d = dec_eol;
          dptr_d = dptr_q + 4 * STEP; st_d = S_BEAT;
        end
      end
      S_BEAT: begin
        if (stop_i) begin midx_d = '0; st_d = S_MARK_REQ; end
        else if (left_q == '0) begin
          midx_d = '0;
          st_d = eol_q ? S_MARK_REQ : S_DADDR_REQ;
        end
        else st_d = dir_q ? S_DEV_WAIT : S_MEM_REQ;
      end
      S_DEV_WAIT: begin
        dev_in_ready_o = !stop_i;
        if (stop_i) begin midx_d = '0; st_d = S_MARK_REQ; end
        else if (dev_in_valid_i) begin
          data_d = dev_in_data_i; dcnt_d = dcnt_q + STEP; st_d = S_MEM_REQ;
        end
      end
      S_MEM_REQ: begin
        mem_req_valid_o = 1'b1;
        mem_req_write_o = dir_q;
        mem_req_addr_o  = baddr_q;
        if (mem_req_ready_i) st_d = S_MEM_WAIT;
      end
      S_MEM_WAIT: if (mem_rsp_valid_i) begin
        if (mem_rsp_err_i) begin err_o = 1'b1; st_d = S_IDLE; end
        else begin
          mcnt_d = mcnt_q + STEP;
          if (dir_q) begin
            baddr_d = baddr_q + STEP; left_d = left_q - WCNT_W'(1); st_d = S_BEAT;
          end else begin
            data_d = mem_rsp_rdata_i; st_d = S_DEV_PUSH;
          end
        end
      end
      S_DEV_PUSH: begin
        dev_out_valid_o = 1'b1;
        if (dev_out_ready_i) begin
          dcnt_d = dcnt_q + STEP; baddr_d = baddr_q + STEP;
          left_d = left_q - WCNT_W'(1); st_d = S_BEAT;
        end
      end
      S_MARK_REQ: begin
        mem_req_valid_o = 1'b1;
        mem_req_write_o = 1'b1;
        mem_req_addr_o  = done_base_i + (DATA_W'(midx_q) << 2);
        mem_req_wdata_o = '1;
        if (mem_req_ready_i) st_d = S_MARK_WAIT;
      end
      S_MARK_WAIT: if (mem_rsp_valid_i) begin
        if (mem_rsp_err_i) begin err_o = 1'b1; st_d = S_IDLE; end
        else if (midx_q == MARK_W'(MARK_WORDS - 1)) begin irq_d = 1'b1; st_d = S_IDLE; end
        else begin midx_d = midx_q + MARK_W'(1); st_d = S_MARK_REQ; end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; dir_q <= 1'b0; eol_q <= 1'b0; irq_q <= 1'b0;
      dptr_q <= '0; baddr_q <= '0; data_q <= '0;
      dcnt_q <= '0; mcnt_q <= '0; left_q <= '0; midx_q <= '0;
    end else begin
      st_q <= st_d; dir_q <= dir_d; eol_q <= eol_d; irq_q <= irq_d;
      dptr_q <= dptr_d; baddr_q <= baddr_d; data_q <= data_d;
      dcnt_q <= dcnt_d; mcnt_q <= mcnt_d; left_q <= left_d; midx_q <= midx_d;
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o
      && $stable(mem_req_addr_o) && $stable(mem_req_write_o) && $stable(mem_req_wdata_o));

  // R9
  err_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !active_o && !irq_o);

  // R7
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !active_o && !mem_req_valid_o);

  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
endmodule

// File: rtl/sg_dma_engine.sv
module sg_dma_engine
  import sg_dma_pkg::*;
#(
  parameter int MARK_WORDS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  reg_addr,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic        mem_req_write,
  output logic [31:0] mem_req_addr,
  output logic [31:0] mem_req_wdata,
  input  logic        mem_rsp_valid,
  input  logic        mem_rsp_err,
  input  logic [31:0] mem_rsp_rdata,
  input  logic        dev_in_valid,
  output logic        dev_in_ready,
  input  logic [31:0] dev_in_data,
  output logic        dev_out_valid,
  input  logic        dev_out_ready,
  output logic [31:0] dev_out_data,
  output logic        irq
);
  logic rst_meta, rst_sync_n;
  logic busy, active, err_set, halt_ack, start, start_dir, stop;
  logic [DATA_W-1:0] cur_addr, dev_cnt, mem_cnt, list_base, done_base;

  // Reset asserts at once and leaves on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  sg_dma_regs regs_i (
    .clk(clk), .rst_n(rst_sync_n),
    .reg_addr_i(reg_addr), .reg_we_i(reg_we), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata),
    .busy_i(busy), .active_i(active), .err_set_i(err_set), .halt_ack_i(halt_ack),
    .cur_addr_i(cur_addr), .dev_cnt_i(dev_cnt), .mem_cnt_i(mem_cnt),
    .start_o(start), .start_dir_o(start_dir), .stop_o(stop),
    .list_base_o(list_base), .done_base_o(done_base)
  );

  sg_dma_seq #(.MARK_WORDS(MARK_WORDS)) seq_i (
    .clk(clk), .rst_n(rst_sync_n),
    .start_i(start), .start_dir_i(start_dir), .stop_i(stop),
    .list_base_i(list_base), .done_base_i(done_base),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
    .mem_req_write_o(mem_req_write), .mem_req_addr_o(mem_req_addr),
    .mem_req_wdata_o(mem_req_wdata),
    .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_err_i(mem_rsp_err),
    .mem_rsp_rdata_i(mem_rsp_rdata),
    .dev_in_valid_i(dev_in_valid), .dev_in_ready_o(dev_in_ready),
    .dev_in_data_i(dev_in_data),
    .dev_out_valid_o(dev_out_valid), .dev_out_ready_i(dev_out_ready),
    .dev_out_data_o(dev_out_data),
    .busy_o(busy), .active_o(active), .err_o(err_set), .halt_ack_o(halt_ack),
    .irq_o(irq), .cur_addr_o(cur_addr), .dev_cnt_o(dev_cnt), .mem_cnt_o(mem_cnt)
  );
endmodule

// File: tb/sg_dma_engine_tb_top.sv
module sg_dma_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;
  logic        dev_in_ready, dev_out_valid, irq;
  logic        src_en = 1'b0;
  logic [31:0] src_base = '0;
  int          src_n = 0;
  logic [31:0] dev_out_data;
  logic        dev_out_ready = 1'b1;

  logic [31:0] mem [0:1023];
  logic [31:0] sink [0:63];
  int sink_n = 0, irq_cnt = 0, cyc = 0, errors = 0, checks = 0;
  bit ready_toggle = 1'b0;

  always #10 clk = ~clk;

  sg_dma_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_err(mem_rsp_err), .mem_rsp_rdata(mem_rsp_rdata),
    .dev_in_valid(src_en), .dev_in_ready(dev_in_ready), .dev_in_data(src_base + 32'(src_n)),
    .dev_out_valid(dev_out_valid), .dev_out_ready(dev_out_ready),
    .dev_out_data(dev_out_data), .irq(irq)
  );

  // Memory model: one cycle response, addresses with top nibble F fail
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    mem_rsp_err   <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      if (mem_req_addr[31:28] == 4'hF) mem_rsp_err <= 1'b1;
      else if (mem_req_write) mem[mem_req_addr[11:2]] <= mem_req_wdata;
      else mem_rsp_rdata <= mem[mem_req_addr[11:2]];
    end
    if (src_en && dev_in_ready) src_n <= src_n + 1;
    if (dev_out_valid && dev_out_ready) begin
      if (sink_n < 64) sink[sink_n] <= dev_out_data;
      sink_n <= sink_n + 1;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (irq) irq_cnt++;
    mem_req_ready <= ready_toggle ? cyc[0] : 1'b1;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [31:0] bsw(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    peek(a, d);
  endtask

  task automatic put_desc(input int word, input logic [31:0] buf_a, input logic [15:0] len, input bit eol);
    mem[word]     = 32'h0;
    mem[word + 1] = bsw(buf_a);
    mem[word + 2] = 32'h0;
    mem[word + 3] = bsw({eol, 15'h0, len});
  endtask

  task automatic clear_done();
    for (int i = 0; i < 32; i++) mem[128 + i] = 32'h0;
  endtask

  task automatic check_done(input string tag);
    int bad = 0;
    for (int i = 0; i < 32; i++) if (mem[128 + i] !== 32'hFFFF_FFFF) bad++;
    chk_eq(tag, 32'(bad), 32'd0);
  endtask

  // Wait for the interrupt; read control in the same half cycle
  task automatic wait_irq(input int limit, input string tag, output logic [31:0] ctrl_at_irq);
    int start_cnt = irq_cnt;
    ctrl_at_irq = 32'hDEAD_BEEF;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      #2;
      if (irq) begin
        peek(4'd7, ctrl_at_irq);
        break;
      end
    end
    chk_eq({tag, " irq pulse"}, 32'(irq_cnt - start_cnt), 32'd1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    reg_read(4'd7, v); chk_eq("R1 ctrl after reset", v, 0);
    reg_read(4'd5, v); chk_eq("R1 dev count after reset", v, 0);
    reg_read(4'd6, v); chk_eq("R1 mem count after reset", v, 0);
    reg_read(4'd0, v); chk_eq("R1 timing after reset", v, 0);
    chk_eq("R1 irq after reset", {31'h0, irq}, 0);
    chk_eq("R10 no request after reset", {31'h0, mem_req_valid}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    reg_write(4'd0, 32'hA5A5_1234);
    reg_write(4'd2, 32'h0000_DEAD);
    reg_write(4'd8, 32'h0000_0200);
    reg_read(4'd0, v); chk_eq("R1 timing readback", v, 32'hA5A5_1234);
    reg_read(4'd2, v); chk_eq("R1 list high readback", v, 32'h0000_DEAD);
    reg_read(4'd8, v); chk_eq("R1 done base readback", v, 32'h0000_0200);
    reg_read(4'd4, v); chk_eq("R1 current high reads zero", v, 0);
  endtask

  task automatic t_mem_to_dev();
    logic [31:0] v, c;
    put_desc(0, 32'h400, 16'd8, 1'b0);
    put_desc(4, 32'h480, 16'd12, 1'b1);
    for (int i = 0; i < 2; i++) mem[256 + i] = 32'h1100_0000 + 32'(i);
    for (int i = 0; i < 3; i++) mem[288 + i] = 32'h2200_0000 + 32'(i);
    clear_done();
    sink_n = 0;
    ready_toggle = 1'b1;
    reg_write(4'd1, 32'h0);
    reg_write(4'd7, 32'h1);
    wait_irq(2000, "R7 mem-to-dev", c);
    chk_eq("R7 active low at irq", c & 32'h8, 0);
    ready_toggle = 1'b0;
    cycles(2);
    chk_eq("R3 word count to device", 32'(sink_n), 5);
    chk_eq("R3 R2 first word", sink[0], 32'h1100_0000);
    chk_eq("R3 second word", sink[1], 32'h1100_0001);
    chk_eq("R3 R2 second descriptor first word", sink[2], 32'h2200_0000);
    chk_eq("R3 last word", sink[4], 32'h2200_0002);
    reg_read(4'd5, v); chk_eq("R5 dev count", v, 20);
    reg_read(4'd6, v); chk_eq("R5 mem count", v, 20);
    reg_read(4'd3, v); chk_eq("R5 current address", v, 32'h48C);
    reg_read(4'd7, v); chk_eq("R7 ctrl idle after done", v, 0);
    check_done("R7 completion area all ones");
  endtask

  task automatic t_dev_to_mem();
    logic [31:0] v, c;
    put_desc(16, 32'h600, 16'd16, 1'b1);
    for (int i = 0; i < 4; i++) mem[384 + i] = 32'h0;
    clear_done();
    src_n = 0; src_base = 32'hC0DE_0000; src_en = 1'b1;
    reg_write(4'd1, 32'h40);
    reg_write(4'd7, 32'h5);
    wait_irq(2000, "R4 dev-to-mem", c);
    src_en = 1'b0;
    cycles(2);
    chk_eq("R4 memory word 0", mem[384], 32'hC0DE_0000);
    chk_eq("R4 memory word 3", mem[387], 32'hC0DE_0003);
    reg_read(4'd5, v); chk_eq("R5 dev count dev-to-mem", v, 16);
    reg_read(4'd6, v); chk_eq("R5 mem count dev-to-mem", v, 16);
    reg_read(4'd7, v); chk_eq("R4 ctrl keeps direction", v, 32'h4);
    check_done("R7 completion after dev-to-mem");
  endtask

  task automatic t_zero_len();
    logic [31:0] v, c;
    put_desc(32, 32'h1000, 16'd0, 1'b1);
    src_n = 0; src_base = 32'h0; src_en = 1'b1;
    reg_write(4'd1, 32'h80);
    reg_write(4'd7, 32'h5);
    wait_irq(100000, "R6 zero length", c);
    src_en = 1'b0;
    cycles(2);
    reg_read(4'd6, v); chk_eq("R6 mem count for zero length", v, 32'h1_0000);
    reg_read(4'd5, v); chk_eq("R6 dev count for zero length", v, 32'h1_0000);
    reg_read(4'd3, v); chk_eq("R6 end address", v, 32'h1_1000);
    chk_eq("R6 device words taken", 32'(src_n), 16384);
  endtask

  task automatic t_stop();
    logic [31:0] v, c;
    int n0;
    put_desc(48, 32'h600, 16'd64, 1'b1);
    clear_done();
    src_en = 1'b0;
    reg_write(4'd1, 32'hC0);
    reg_write(4'd7, 32'h5);
    cycles(8);
    reg_read(4'd7, v); chk_eq("R8 running before stop", v, 32'hC);
    reg_write(4'd7, 32'h2);
    cycles(3);
    reg_read(4'd7, v); chk_eq("R8 stop pending, dir kept, active low", v, 32'h6);
    wait_irq(2000, "R8 stop", c);
    cycles(3);
    reg_read(4'd7, v); chk_eq("R8 stop bit released", v, 32'h4);
    reg_read(4'd6, v); chk_eq("R8 no memory data moved", v, 0);
    check_done("R8 completion after stop");
    n0 = irq_cnt;
    reg_write(4'd7, 32'h2);
    peek(4'd7, v); chk_eq("R8 idle stop reads one", v, 32'h2);
    cycles(2);
    peek(4'd7, v); chk_eq("R8 idle stop clears", v, 0);
    chk_eq("R8 idle stop gives no irq", 32'(irq_cnt - n0), 0);
  endtask

  task automatic t_error();
    logic [31:0] v;
    int n0 = irq_cnt;
    put_desc(64, 32'hF000_0000, 16'd8, 1'b1);
    clear_done();
    reg_write(4'd1, 32'h100);
    reg_write(4'd7, 32'h1);
    cycles(20);
    reg_read(4'd7, v); chk_eq("R9 error set and halted", v, 32'h10);
    chk_eq("R9 no irq on error", 32'(irq_cnt - n0), 0);
    chk_eq("R9 no completion write", mem[128], 0);
    reg_write(4'd7, 32'h1);
    cycles(2);
    reg_read(4'd7, v); chk_eq("R9 start ignored while error", v, 32'h10);
    reg_write(4'd7, 32'h2);
    cycles(3);
    reg_read(4'd7, v); chk_eq("R9 stop write clears error", v, 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    cycles(3);
    rst_n = 1'b1;
    cycles(4);
    t_reset();
    t_regs();
    t_mem_to_dev();
    t_dev_to_mem();
    t_zero_len();
    t_stop();
    t_error();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule